// File: doc/BRIEF.md
# Floating-point Operand Class Tester

This block decides whether a single double-precision operand falls into any of a set of value classes picked at run time by a 9-bit selection mask. The operand is a 64-bit IEEE 754 double together with a flag marking it as a not-a-thing (NaT) placeholder. Software uses the result to screen operands before a computation, for example to reject bad square-root inputs or to take an early exit.

The answer comes back as two complementary predicate bits, hit and miss, registered one cycle after the request. A request carries a valid strobe and a qualifying enable. When the enable is low, the predicates are left untouched, but the output valid still pulses.

The mask mixes sign selectors with type selectors. A finite or infinite number matches only when both its sign and its type are selected. A NaN ignores the sign selectors. A NaT operand is judged by its own mask bit alone.

Top module: `fp_class_tester`

## Requirements
- R1: After reset, `out_valid` is 0, `out_hit` is 0 and `out_miss` is 1.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, whatever the value of `in_qual`.
- R3: `out_miss` is always the logical inverse of `out_hit`.
- R4: When `in_nat` is 1, the operand matches exactly when mask bit 8 is 1, whatever the other mask bits and operand bits are.
- R5: When `in_nat` is 0, the exponent field (bits 62:52) is all ones and the fraction (bits 51:0) is nonzero, the operand is a NaN. If fraction bit 51 is 1 it is quiet and matches on mask bit 7. Otherwise it is signaling and matches on mask bit 6. Mask bits 0 and 1 have no effect on a NaN.
- R6: Type decode for a non-NaT, non-NaN operand:
  - exponent all ones with a zero fraction is infinity (mask bit 5);
  - exponent zero with a zero fraction is zero (mask bit 2);
  - exponent zero with a nonzero fraction is unnormal (mask bit 3);
  - any other exponent is normal (mask bit 4).
- R7: A non-NaT, non-NaN operand matches only when its type bit is set and the bit for its sign (bit 63) is also set: mask bit 0 for positive, mask bit 1 for negative.
- R8: Mask 0x1E3 matches a NaT, both kinds of NaN and both infinities, and matches no finite number.
- R9: Mask 0x01A matches negative normal and negative unnormal operands only. Positive values, negative zero and negative infinity do not match.
- R10: A request with `in_qual` low leaves `out_hit` and `out_miss` unchanged.
- R11: The two-step square-root screen reports an invalid operand exactly for NaT, NaN, infinity and negative nonzero values. The first test uses mask 0x1E3. The second uses mask 0x01A and runs only when the first did not match.
- R12: A cycle with `in_valid` low leaves `out_hit` and `out_miss` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_qual | input | 1 | Qualifying enable; when low, the predicates hold their values |
| in_nat | input | 1 | Operand is a not-a-thing placeholder |
| in_operand | input | 64 | IEEE 754 double operand |
| in_mask | input | 9 | Class selection mask |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_hit | output | 1 | Operand belongs to a selected class |
| out_miss | output | 1 | Inverse of `out_hit` |

## Verification
The assertions assume that `in_mask`, `in_nat` and `in_operand` are stable and known whenever `in_valid` is high at a clock edge. They also assume that the hold properties apply only when no qualified request is present. The bench drives every input on the falling edge, one request per two clocks, so each request's inputs are settled at the capturing edge. Random operands are drawn so that every exponent corner (zero, all ones, ordinary) appears with a zero or nonzero fraction and with either sign.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int MASK_W = 9;
  localparam int KIND_N = 6;

  // Mask bit positions
  localparam int MB_POS  = 0;
  localparam int MB_NEG  = 1;
  localparam int MB_KIND = 2;  // kinds occupy MB_KIND .. MB_KIND+KIND_N-1
  localparam int MB_NAT  = 8;

  // Kind indices (offset from MB_KIND)
  localparam int K_ZERO  = 0;
  localparam int K_UNORM = 1;
  localparam int K_NORM  = 2;
  localparam int K_INF   = 3;
  localparam int K_SNAN  = 4;
  localparam int K_QNAN  = 5;

  typedef struct packed {
    logic              nat;
    logic              neg;
    logic [KIND_N-1:0] kind;
  } fpc_class_t;

  function automatic logic sign_selected(input logic neg, input logic [MASK_W-1:0] m);
    return neg ? m[MB_NEG] : m[MB_POS];
  endfunction
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    nat,
  input  logic [EXP_W+FRAC_W:0]   operand,
  output fpc_pkg::fpc_class_t     cls
);
  import fpc_pkg::*;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_min, frac_nz, quiet_bit;

  assign exp_f     = operand[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f    = operand[FRAC_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_min   = ~|exp_f;
  assign frac_nz   = |frac_f;
  assign quiet_bit = frac_f[FRAC_W-1];

  always_comb begin
    cls      = '0;
    cls.nat  = nat;
    cls.neg  = operand[EXP_W+FRAC_W];
    cls.kind[K_ZERO]  = exp_min & ~frac_nz;
    cls.kind[K_UNORM] = exp_min &  frac_nz;
    cls.kind[K_NORM]  = ~exp_min & ~exp_max;
    cls.kind[K_INF]   = exp_max & ~frac_nz;
    cls.kind[K_SNAN]  = exp_max &  frac_nz & ~quiet_bit;
    cls.kind[K_QNAN]  = exp_max &  frac_nz &  quiet_bit;
  end
endmodule

// File: rtl/fpc_match.sv
module fpc_match (
  input  fpc_pkg::fpc_class_t                cls,
  input  logic [fpc_pkg::MASK_W-1:0]         mask,
  output logic                               hit,
  output logic                               kind_hit,
  output logic                               is_nan
);
  import fpc_pkg::*;

  logic [KIND_N-1:0] sel;
  logic sign_ok;

  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    assign sel[k] = cls.kind[k] & mask[MB_KIND+k];
  end

  assign kind_hit = |sel;
  assign is_nan   = cls.kind[K_SNAN] | cls.kind[K_QNAN];
  assign sign_ok  = is_nan | sign_selected(cls.neg, mask);
  assign hit      = cls.nat ? mask[MB_NAT] : (kind_hit & sign_ok);
endmodule

// File: rtl/fp_class_tester.sv
module fp_class_tester #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_qual,
  input  logic                          in_nat,
  input  logic [EXP_W+FRAC_W:0]         in_operand,
  input  logic [fpc_pkg::MASK_W-1:0]    in_mask,
  output logic                          out_valid,
  output logic                          out_hit,
  output logic                          out_miss
);
  import fpc_pkg::*;

  fpc_class_t cls;
  logic raw_hit, kind_hit, is_nan, load_en;

  fpc_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
    .nat     (in_nat),
    .operand (in_operand),
    .cls     (cls)
  );

  fpc_match u_match (
    .cls      (cls),
    .mask     (in_mask),
    .hit      (raw_hit),
    .kind_hit (kind_hit),
    .is_nan   (is_nan)
  );

  assign load_en = in_valid & in_qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        out_hit  <= raw_hit;
        out_miss <= ~raw_hit;
      end
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_qual,
  input logic                       in_nat,
  input logic [63:0]                in_operand,
  input logic [fpc_pkg::MASK_W-1:0] in_mask,
  input logic                       out_valid,
  input logic                       out_hit,
  input logic                       out_miss,
  input fpc_pkg::fpc_class_t        cls,
  input logic                       is_nan
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_complement: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit != out_miss);
  a_r4_nat_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_qual && in_nat && in_mask[8]) |=> out_hit);
  a_r4_nat_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_qual && in_nat && !in_mask[8]) |=> !out_hit);
  a_r5_nan_sign_free: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_qual && !in_nat && (&in_operand[62:52]) && (|in_operand[51:0])
     && in_mask[7:6] == 2'b11) |=> out_hit);
  a_r6_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones(cls.kind) == 1);
  a_r7_sign_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_qual && !in_nat && !is_nan && in_mask[1:0] == 2'b00) |=> !out_hit);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_qual) |=> $stable(out_hit));
endmodule

bind fp_class_tester fpc_checker u_fpc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_qual    (in_qual),
  .in_nat     (in_nat),
  .in_operand (in_operand),
  .in_mask    (in_mask),
  .out_valid  (out_valid),
  .out_hit    (out_hit),
  .out_miss   (out_miss),
  .cls        (cls),
  .is_nan     (is_nan)
);

// File: tb/fp_class_tester_bench.sv
`timescale 1ns/1ps
module fp_class_tester_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_qual = 1'b0, in_nat = 1'b0;
  logic [63:0] in_operand = '0;
  logic [8:0]  in_mask = '0;
  logic        out_valid, out_hit, out_miss;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_valid = 0, exp_hit = 0;

  always #2.5 clk = ~clk;

  fp_class_tester u_fp_class_tester (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_qual(in_qual),
    .in_nat(in_nat), .in_operand(in_operand), .in_mask(in_mask),
    .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss)
  );

  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P_FOUR = 64'h4010_0000_0000_0000;
  localparam logic [63:0] N_FOUR = 64'hC010_0000_0000_0000;
  localparam logic [63:0] P_ZERO = 64'h0;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] N_DEN  = 64'h8000_0000_0000_0003;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] N_SNAN = 64'hFFF0_0000_0000_0001;

  // Behavioural class test from the requirement text
  function automatic bit ref_match(logic [63:0] v, bit nat, logic [8:0] m);
    int unsigned e = v[62:52];
    longint unsigned f = v[51:0];
    int sbit = v[63] ? 1 : 0;
    if (nat) return m[8];
    if (e == 2047) begin
      if (f != 0) return v[51] ? m[7] : m[6];
      return m[5] && m[sbit];
    end
    if (e == 0) return (f == 0 ? m[2] : m[3]) && m[sbit];
    return m[4] && m[sbit];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Cycle model, compared every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 0; exp_hit <= 0;
    end else begin
      exp_valid <= in_valid;
      if (in_valid && in_qual) exp_hit <= ref_match(in_operand, in_nat, in_mask);
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 out_valid", out_valid, exp_valid);
    check("R3 out_miss", out_miss, !exp_hit);
    check("R10/R12 model out_hit", out_hit, exp_hit);
  end

  task automatic apply(string tag, logic [63:0] op, bit nat, logic [8:0] m, bit qual, bit expect_hit);
    @(negedge clk);
    in_valid = 1; in_qual = qual; in_nat = nat; in_operand = op; in_mask = m;
    @(negedge clk);
    in_valid = 0; in_qual = 0;
    check(tag, out_hit, expect_hit);
    check({tag, " valid"}, out_valid, 1'b1);
  endtask

  task automatic screen(logic [63:0] op, bit nat, bit expect_bad);
    bit first, second;
    second = 0;
    apply("R11 step1", op, nat, 9'h1E3, 1, ref_match(op, nat, 9'h1E3));
    first = out_hit;
    if (!first) begin
      apply("R11 step2", op, nat, 9'h01A, 1, ref_match(op, nat, 9'h01A));
      second = out_hit;
    end
    check("R11 screen verdict", first || second, expect_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_hit", out_hit, 0);
    check("R1 out_miss", out_miss, 1);
    rst_n = 1;

    apply("R7 +1 pos-normal", P_ONE, 0, 9'h011, 1, 1);
    apply("R7 -1 pos-normal", N_ONE, 0, 9'h011, 1, 0);
    apply("R6 +0 zero", P_ZERO, 0, 9'h005, 1, 1);
    apply("R6 -den unorm", N_DEN, 0, 9'h00A, 1, 1);
    apply("R6 -den not normal", N_DEN, 0, 9'h013, 1, 0);
    apply("R6 +inf", P_INF, 0, 9'h021, 1, 1);
    apply("R4 nat no bit8", P_ONE, 1, 9'h0FF, 1, 0);
    apply("R4 nat bit8", P_ONE, 1, 9'h100, 1, 1);
    apply("R5 qnan no sign bits", QNAN, 0, 9'h080, 1, 1);
    apply("R5 snan no sign bits", N_SNAN, 0, 9'h040, 1, 1);
    apply("R5 snan not quiet", N_SNAN, 0, 9'h083, 1, 0);
    apply("R8 nat", P_ZERO, 1, 9'h1E3, 1, 1);
    apply("R8 qnan", QNAN, 0, 9'h1E3, 1, 1);
    apply("R8 snan", N_SNAN, 0, 9'h1E3, 1, 1);
    apply("R8 +inf", P_INF, 0, 9'h1E3, 1, 1);
    apply("R8 -inf", N_INF, 0, 9'h1E3, 1, 1);
    apply("R8 +1", P_ONE, 0, 9'h1E3, 1, 0);
    apply("R9 -1", N_ONE, 0, 9'h01A, 1, 1);
    apply("R9 -den", N_DEN, 0, 9'h01A, 1, 1);
    apply("R9 -0", N_ZERO, 0, 9'h01A, 1, 0);
    apply("R9 +1", P_ONE, 0, 9'h01A, 1, 0);
    apply("R9 -inf", N_INF, 0, 9'h01A, 1, 0);
    // R10: hit is 0 now; unqualified request that would match holds it
    apply("R10 qual low holds", N_ONE, 0, 9'h01A, 0, 0);
    apply("R7 set hit", N_ONE, 0, 9'h01A, 1, 1);
    apply("R10 qual low holds hit", P_ONE, 0, 9'h000, 0, 1);
    // R12: idle cycle with mismatching inputs and qual high
    @(negedge clk);
    in_valid = 0; in_qual = 1; in_mask = 9'h000; in_operand = P_ONE;
    @(negedge clk);
    check("R12 idle out_hit", out_hit, 1);
    check("R12 idle out_valid", out_valid, 0);
    in_qual = 0;

    screen(P_FOUR, 0, 0);
    screen(N_FOUR, 0, 1);
    screen(N_ZERO, 0, 0);
    screen(QNAN, 0, 1);
    screen(P_ONE, 1, 1);
    screen(N_DEN, 0, 1);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] op;
      logic [8:0] m;
      bit nat;
      op = {$urandom, $urandom};
      case ($urandom % 4)
        0: op[62:52] = '0;
        1: op[62:52] = '1;
        default: ;
      endcase
      if ($urandom % 3 == 0) op[51:0] = '0;
      m = 9'($urandom);
      nat = ($urandom % 8) == 0;
      apply("R6/R7 random", op, nat, m, 1, ref_match(op, nat, m));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule